// File: doc/BRIEF.md
# UART Receive Status and Modem-Change Registers

This block is the read-side status logic of a single UART channel. A receiver reports break, framing, parity and overrun events as one-cycle pulses. Each pulse sets its own sticky flag, and the flag stays set until software reads the error word. The block also packs the fill levels of the transmit and receive FIFOs into a FIFO status word. Each FIFO gets a 4-bit count and a separate full flag for the sixteenth entry.

The active-low clear-to-send pin passes through a synchronizer. Its current level is reported in the modem word. Any change of the pin since the last modem read is latched into a change bit.

Software reads one of the three words with a one-cycle read strobe. The selected word appears on a registered data output one cycle later, with a valid flag. Reading the error word or the modem word clears that word's sticky bits. An event that lands in the same cycle as the clearing read survives the clear.

The overrun flag follows one extra rule. After an overrun, the receive data register must be read. Until then, every newly received byte raises overrun again.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, the error word reads 0x0000. The modem word with the clear-to-send pin held high reads 0x0000. The FIFO word with both levels at 0 reads 0x0000.
- R2: Error word bit positions are fixed: break in bit 3, framing error in bit 2, parity error in bit 1 and overrun in bit 0. A pulse on an error input sets its bit. The bit stays 1 until the error word is read. Bits 15:4 read 0.
- R3: A read of the error word returns the flags as they were before the read. After the read, all four flags are 0 unless a new event arrived.
- R4: An error pulse in the same cycle as an error-word read is not lost. That read does not show it, and the next error-word read does.
- R5: An overrun pulse arms a stale-data condition. While it is armed, every received-byte pulse sets the overrun flag again. A pulse on the receive-data-read input disarms the condition. After that, received-byte pulses leave the overrun flag at 0.
- R6: FIFO word layout: transmit full in bit 9, receive full in bit 8, transmit count in bits 7:4 and receive count in bits 3:0. Bits 15:10 read 0.
- R7: A FIFO level of 0 to 15 shows as that count, with the full bit at 0. A level of 16 shows full=1 with the count field at 0.
- R8: Modem word bit 0 is 1 when the active-low clear-to-send pin is low, and 0 when it is high. Bits 3:1 and bits 15:5 read 0. A pin change is visible within 3 cycles.
- R9: Modem word bit 4 is 1 when the synchronized pin has changed since the previous modem-word read. It stays 1 through further changes, including a return to the original level. A modem read clears it.
- R10: A synchronized pin change detected in the same cycle as a modem-word read keeps bit 4 set for the following modem read.
- R11: The read data is valid exactly one cycle after a read strobe. If several strobes are high at once, the error word has the highest priority and the FIFO word the next. Only the word actually returned has its sticky bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_evt_i | input | 1 | Break detected pulse |
| frm_evt_i | input | 1 | Framing error pulse |
| par_evt_i | input | 1 | Parity error pulse |
| ovr_evt_i | input | 1 | Overrun pulse |
| rx_byte_i | input | 1 | A byte was received |
| rx_data_rd_i | input | 1 | Receive data register was read |
| tx_lvl_i | input | 5 | Transmit FIFO fill level, 0 to 16 |
| rx_lvl_i | input | 5 | Receive FIFO fill level, 0 to 16 |
| cts_n_i | input | 1 | Clear-to-send pin, active low, asynchronous |
| rd_err_i | input | 1 | Read strobe, error word |
| rd_fifo_i | input | 1 | Read strobe, FIFO word |
| rd_modem_i | input | 1 | Read strobe, modem word |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 16 | Read data |

## Verification
The bench builds the block with its defaults: a FIFO depth of 16, a 16-bit word and a two-stage synchronizer. This puts the 15-to-16 full boundary, including both FIFOs full at once, directly in reach. It also makes the clear-to-send latency short enough to place a detected pin change in exactly the cycle of a modem read. With those values the bench drives same-cycle event-versus-clear collisions on both sticky words. It also checks that overrun is raised again until the receive data is read, and that a read with several strobes clears only the word it returns.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_ERR, SEL_FIFO, SEL_MODEM} rd_sel_e;
  localparam int ERR_BITS        = 4;
  localparam int BIT_OVR         = 0;
  localparam int BIT_PAR         = 1;
  localparam int BIT_FRM         = 2;
  localparam int BIT_BRK         = 3;
  localparam int MODEM_LVL_BIT   = 0;
  localparam int MODEM_DELTA_BIT = 4;
endpackage

// File: rtl/uart_err_sticky.sv
module uart_err_sticky
  import uart_stat_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                brk_i,
  input  logic                frm_i,
  input  logic                par_i,
  input  logic                ovr_i,
  input  logic                rx_byte_i,
  input  logic                rx_data_rd_i,
  input  logic                clr_i,
  output logic [ERR_BITS-1:0] err_o
);
  logic [ERR_BITS-1:0] err_q;
  logic [ERR_BITS-1:0] evt;
  logic                stale_q;
  logic                reraise;

  // Overrun is raised again by each new byte until receive data is read.
  assign reraise = stale_q & rx_byte_i;

  always_comb begin
    evt          = '0;
    evt[BIT_BRK] = brk_i;
    evt[BIT_FRM] = frm_i;
    evt[BIT_PAR] = par_i;
    evt[BIT_OVR] = ovr_i | reraise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q   <= '0;
      stale_q <= 1'b0;
    end else begin
      err_q   <= (err_q & ~{ERR_BITS{clr_i}}) | evt;
      stale_q <= (stale_q & ~rx_data_rd_i) | ovr_i;
    end
  end

  assign err_o = err_q;

  // R2
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (($past(err_q) & ~err_q) == '0));
  // R3
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !brk_i && !frm_i && !par_i && !ovr_i && !(stale_q && rx_byte_i))
      |=> (err_q == '0));
  // R4
  err_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && brk_i) |=> err_q[BIT_BRK]);
  // R5
  ovr_reraise_chk: assert property (@(posedge clk) disable iff (rst)
    (stale_q && rx_byte_i) |=> err_q[BIT_OVR]);
endmodule

// File: rtl/uart_fifo_word.sv
module uart_fifo_word #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(DEPTH),
  localparam int LVL_W = CNT_W + 1
) (
  input  logic [LVL_W-1:0]  tx_lvl_i,
  input  logic [LVL_W-1:0]  rx_lvl_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int RX_CNT_LO = 0;
  localparam int TX_CNT_LO = CNT_W;
  localparam int RX_FULL   = 2 * CNT_W;
  localparam int TX_FULL   = 2 * CNT_W + 1;

  logic tx_full, rx_full;

  assign tx_full = (tx_lvl_i >= LVL_W'(DEPTH));
  assign rx_full = (rx_lvl_i >= LVL_W'(DEPTH));

  always_comb begin
    word_o                          = '0;
    word_o[RX_CNT_LO +: CNT_W]      = rx_full ? '0 : rx_lvl_i[CNT_W-1:0];
    word_o[TX_CNT_LO +: CNT_W]      = tx_full ? '0 : tx_lvl_i[CNT_W-1:0];
    word_o[RX_FULL]                 = rx_full;
    word_o[TX_FULL]                 = tx_full;
  end
endmodule

// File: rtl/uart_cts_watch.sv
module uart_cts_watch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_n_i,
  input  logic clr_i,
  output logic cts_act_o,
  output logic delta_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ref_q;
  logic                   delta_q;
  logic                   pin_s;
  logic                   changed;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) sync_q <= cts_n_i;
    end else begin : g_chain
      always_ff @(posedge clk) sync_q <= {sync_q[SYNC_STAGES-2:0], cts_n_i};
    end
  endgenerate

  assign pin_s   = sync_q[SYNC_STAGES-1];
  assign changed = (pin_s != ref_q);

  // The reference follows the synchronized pin, and is loaded during reset too.
  always_ff @(posedge clk) ref_q <= pin_s;

  always_ff @(posedge clk) begin
    if (rst) delta_q <= 1'b0;
    else     delta_q <= (delta_q & ~clr_i) | changed;
  end

  assign cts_act_o = ~pin_s;
  assign delta_o   = delta_q;

  // R9
  cts_delta_set_chk: assert property (@(posedge clk) disable iff (rst)
    changed |=> delta_q);
  // R9
  cts_delta_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (delta_q && !clr_i) |=> delta_q);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_stat_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int LVL_W      = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              brk_evt_i,
  input  logic              frm_evt_i,
  input  logic              par_evt_i,
  input  logic              ovr_evt_i,
  input  logic              rx_byte_i,
  input  logic              rx_data_rd_i,
  input  logic [LVL_W-1:0]  tx_lvl_i,
  input  logic [LVL_W-1:0]  rx_lvl_i,
  input  logic              cts_n_i,
  input  logic              rd_err_i,
  input  logic              rd_fifo_i,
  input  logic              rd_modem_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o
);
  rd_sel_e             sel;
  logic [ERR_BITS-1:0] err_flags;
  logic [WORD_W-1:0]   fifo_word;
  logic [WORD_W-1:0]   err_word;
  logic [WORD_W-1:0]   modem_word;
  logic                cts_act;
  logic                cts_delta;
  logic [WORD_W-1:0]   mux_word;

  always_comb begin
    if      (rd_err_i)   sel = SEL_ERR;
    else if (rd_fifo_i)  sel = SEL_FIFO;
    else if (rd_modem_i) sel = SEL_MODEM;
    else                 sel = SEL_NONE;
  end

  uart_err_sticky u_err (
    .clk          (clk),
    .rst          (rst),
    .brk_i        (brk_evt_i),
    .frm_i        (frm_evt_i),
    .par_i        (par_evt_i),
    .ovr_i        (ovr_evt_i),
    .rx_byte_i    (rx_byte_i),
    .rx_data_rd_i (rx_data_rd_i),
    .clr_i        (sel == SEL_ERR),
    .err_o        (err_flags)
  );

  uart_fifo_word #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
    .tx_lvl_i (tx_lvl_i),
    .rx_lvl_i (rx_lvl_i),
    .word_o   (fifo_word)
  );

  uart_cts_watch #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk       (clk),
    .rst       (rst),
    .cts_n_i   (cts_n_i),
    .clr_i     (sel == SEL_MODEM),
    .cts_act_o (cts_act),
    .delta_o   (cts_delta)
  );

  always_comb begin
    err_word                  = '0;
    err_word[ERR_BITS-1:0]    = err_flags;
    modem_word                = '0;
    modem_word[MODEM_LVL_BIT]   = cts_act;
    modem_word[MODEM_DELTA_BIT] = cts_delta;
    case (sel)
      SEL_ERR:   mux_word = err_word;
      SEL_FIFO:  mux_word = fifo_word;
      SEL_MODEM: mux_word = modem_word;
      default:   mux_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= (sel != SEL_NONE);
      rd_data_o  <= mux_word;
    end
  end

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_err_i || rd_fifo_i || rd_modem_i) |=> rd_valid_o);
  // R11
  rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_err_i || rd_fifo_i || rd_modem_i) |=> !rd_valid_o);
  // R11
  rd_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_err_i && rd_modem_i && cts_delta) |=> cts_delta);
endmodule

// File: tb/uart_rx_status_tb_top.sv
`timescale 1ns/1ps
module uart_rx_status_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        brk = 0, frm = 0, par = 0, ovr = 0, rxb = 0, rxrd = 0;
  logic [4:0]  tx_lvl = 0, rx_lvl = 0;
  logic        cts_n = 1'b1;
  logic        rd_err = 0, rd_fifo = 0, rd_modem = 0;
  logic        rd_valid;
  logic [15:0] rd_data;

  int errors = 0;
  int checks = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  uart_rx_status dut_i (
    .clk(clk), .rst(rst),
    .brk_evt_i(brk), .frm_evt_i(frm), .par_evt_i(par), .ovr_evt_i(ovr),
    .rx_byte_i(rxb), .rx_data_rd_i(rxrd),
    .tx_lvl_i(tx_lvl), .rx_lvl_i(rx_lvl), .cts_n_i(cts_n),
    .rd_err_i(rd_err), .rd_fifo_i(rd_fifo), .rd_modem_i(rd_modem),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  // Monitor: compares each returned word with the oldest expectation.
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected valid: actual=%h expected=none", rd_data);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: strobes {modem,fifo,err} for one cycle and queues the expectation.
  task automatic rd(logic [2:0] m, logic [15:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_err = m[0]; rd_fifo = m[1]; rd_modem = m[2];
    @(negedge clk);
    rd_err = 0; rd_fifo = 0; rd_modem = 0;
  endtask

  task automatic pulse_err(logic b, logic f, logic p, logic o);
    brk = b; frm = f; par = p; ovr = o;
    @(negedge clk);
    brk = 0; frm = 0; par = 0; ovr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    rd(3'b001, 16'h0000, "R1 err after reset");
    rd(3'b100, 16'h0000, "R1 modem after reset");
    rd(3'b010, 16'h0000, "R1 fifo after reset");

    // R2 / R3
    pulse_err(1, 0, 0, 0);
    tick(2);
    rd(3'b001, 16'h0008, "R2 break bit3");
    rd(3'b001, 16'h0000, "R3 cleared by read");
    pulse_err(0, 1, 1, 0);
    tick(1);
    rd(3'b001, 16'h0006, "R2 frame+parity");
    rd(3'b001, 16'h0000, "R3 cleared again");

    // R4 event in the clearing cycle
    pulse_err(0, 1, 0, 0);
    par = 1;
    rd(3'b001, 16'h0004, "R4 read during parity pulse");
    par = 0;
    rd(3'b001, 16'h0002, "R4 parity kept");

    // R5 overrun re-raise
    pulse_err(0, 0, 0, 1);
    rd(3'b001, 16'h0001, "R5 overrun bit0");
    rxb = 1; tick(1); rxb = 0;
    rd(3'b001, 16'h0001, "R5 raised again by new byte");
    rxrd = 1; tick(1); rxrd = 0;
    rxb = 1; tick(1); rxb = 0;
    rd(3'b001, 16'h0000, "R5 quiet after data read");

    // R6 / R7 FIFO word
    tx_lvl = 5;  rx_lvl = 10; tick(1);
    rd(3'b010, 16'h005A, "R6 layout");
    tx_lvl = 16; rx_lvl = 15; tick(1);
    rd(3'b010, 16'h020F, "R7 tx full, rx 15");
    tx_lvl = 3;  rx_lvl = 16; tick(1);
    rd(3'b010, 16'h0130, "R7 rx full, tx 3");
    tx_lvl = 16; rx_lvl = 16; tick(1);
    rd(3'b010, 16'h0300, "R6 both full");
    tx_lvl = 15; rx_lvl = 0; tick(1);
    rd(3'b010, 16'h00F0, "R7 tx 15 not full");

    // R8 / R9 CTS
    cts_n = 0; tick(5);
    rd(3'b100, 16'h0011, "R8 R9 cts low, changed");
    rd(3'b100, 16'h0001, "R9 delta cleared");
    cts_n = 1; tick(5);
    cts_n = 0; tick(5);
    rd(3'b100, 16'h0011, "R9 delta after round trip");
    rd(3'b100, 16'h0001, "R9 cleared after round trip");

    // R10 change detected in the read cycle
    cts_n = 1; tick(2);
    rd(3'b100, 16'h0000, "R10 read during change");
    rd(3'b100, 16'h0010, "R10 delta kept");
    rd(3'b100, 16'h0000, "R8 pin high level 0");

    // R11 priority and selective clear
    pulse_err(1, 0, 0, 0);
    cts_n = 0; tick(5);
    rd(3'b101, 16'h0008, "R11 err wins over modem");
    rd(3'b100, 16'h0011, "R11 modem not cleared");
    rd(3'b001, 16'h0000, "R11 err cleared");
    rd(3'b110, 16'h00F0, "R11 fifo wins over modem");
    tick(3);

    if (exp_q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R11 missing reads: actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule